// File: doc/BRIEF.md
# Virtual-Function Queue Enable Controller

This block decides which transmit and receive queues of a multi-queue network controller may move traffic when the controller is shared by several virtual functions. Each function owns two queues: function `n` owns the lower queue `n` and the upper queue `n + NUM_FUNC`. Per queue, the block holds a receive enable and a transmit enable. It also holds a global transmit enable, a virtualization-mode flag, one receive-enable and one transmit-enable mask bit per function, and a sticky per-function reset-indication register. Software reaches all of this through a simple write/read register port.

On the transmit side the block produces one registered permit flag per queue. On the receive side it takes a pool selection vector with one bit per function, plus an upper/lower queue select. It narrows the vector to the functions that may receive, expands it onto queues, drops queues whose receive enable is off, and reports which queues take the packet. A function-level reset request clears everything that function owns in one clock edge, records the event, and pulses an interrupt cause that is shared with the mailbox.

Register map (word addresses, 6-bit): `0x00` mode, bit 0 = virtualization mode. `0x01` global transmit control, bit 0 = enable. `0x02` receive function mask. `0x03` transmit function mask. `0x04` reset indication, written 1 to clear. `0x10 + q` receive queue `q` control. `0x20 + q` transmit queue `q` control. In both queue control registers bit 25 is the queue enable. Every unimplemented bit reads 0.

Top module: `vfqe_ctrl`

## Requirements
- R1: After reset, receive queue 0 and transmit queue 0 read back with bit 25 set and every other queue reads 0. Both function masks, the mode bit, the global transmit enable and the reset indication read 0, and every `tx_permit` bit is 0.
- R2: `tx_permit[q]` is 1 only if the global transmit enable (address 0x01, bit 0) is 1 and bit 25 of transmit queue control `q` (address 0x20+q) is 1.
- R3: With the mode bit (address 0x00, bit 0) set, `tx_permit[q]` also requires bit `q mod 8` of the transmit function mask (address 0x03), so function `n` gates queues `n` and `n+8`.
- R4: With the mode bit clear, the transmit function mask has no effect on `tx_permit`.
- R5: `tx_permit` changes on the clock edge after the one that stores the contributing register write.
- R6: The receive selection is `rx_pool_sel` ANDed with the receive function mask (address 0x02). With `rx_odd_sel` = 0 function bit `n` maps to queue `n`. With `rx_odd_sel` = 1 it maps to queue `n+8`.
- R7: `rx_deliver` is registered one cycle after `rx_valid`. It marks only selected queues whose receive queue control (address 0x10+q) has bit 25 set, and it is 0 when `rx_valid` was 0.
- R8: `rx_done` pulses together with `rx_deliver`, and only when at least one queue took the packet. A selection that lands only on disabled queues gives no pulse.
- R9: A function-level reset for `n` (bit `n` of `flr_req`) clears bit 25 of the receive and transmit control of queues `n` and `n+8`, and bit `n` of both function masks. Other functions are left as they were.
- R10: The same reset sets bit `n` of the reset indication (address 0x04). Writing 1 to a bit there clears it, and writing 0 leaves it unchanged.
- R11: `flr_irq` is high for exactly the one cycle after each cycle in which `flr_req` is nonzero.
- R12: When a register write and a function-level reset hit the same bit in the same cycle, the reset's value wins. Queue and mask bits end cleared, and the reset-indication bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| flr_req | input | 8 | Function-level reset request, one bit per function |
| flr_irq | output | 1 | Shared mailbox/reset interrupt cause pulse |
| rx_valid | input | 1 | Receive selection is valid this cycle |
| rx_pool_sel | input | 8 | Receive pool selection, one bit per function |
| rx_odd_sel | input | 1 | Target upper queue of each function |
| rx_deliver | output | 16 | Queues that accept the packet |
| rx_done | output | 1 | Receive-done cause pulse |
| tx_permit | output | 16 | Per-queue transmit permission |

## Verification
A stale or wrongly cleared queue-enable bit shows up in one of two ways. It can be read back directly on the register port in the cycle after the edge that stored it. It also shows on `tx_permit` one edge later, or in `rx_deliver` for the next valid receive. A function reset that misses a queue or clears the wrong function shows up as a neighbour's permission changing, or as a bit that does not drop. The reset-versus-write collision is checked by driving both in the same cycle. The difference between a selected queue and a delivered queue is checked by aiming selections at disabled queues and watching `rx_done`.

// File: rtl/vfqe_pkg.sv
package vfqe_pkg;
   localparam int ADDR_W = 6;
   localparam logic [ADDR_W-1:0] ADR_MODE    = 6'h00;
   localparam logic [ADDR_W-1:0] ADR_TXGLB   = 6'h01;
   localparam logic [ADDR_W-1:0] ADR_RXFMASK = 6'h02;
   localparam logic [ADDR_W-1:0] ADR_TXFMASK = 6'h03;
   localparam logic [ADDR_W-1:0] ADR_RSTIND  = 6'h04;
   localparam int RXQ_BASE = 16;
   localparam int TXQ_BASE = 32;
   localparam int QEN_BIT  = 25;
endpackage

// File: rtl/vfqe_regs.sv
module vfqe_regs
   import vfqe_pkg::*;
#(
   parameter int NUM_FUNC = 8,
   parameter int DATA_W   = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   input  logic [NUM_FUNC-1:0]   flr_req,
   output logic                  virt_mode,
   output logic                  tx_glb,
   output logic [NUM_FUNC-1:0]   rxf_en,
   output logic [NUM_FUNC-1:0]   txf_en,
   output logic [2*NUM_FUNC-1:0] rxq_en,
   output logic [2*NUM_FUNC-1:0] txq_en,
   output logic                  flr_irq
);
   localparam int NQ = 2 * NUM_FUNC;

   if (NUM_FUNC < 1 || NUM_FUNC > 8) begin : g_bad_func
      $error("vfqe_regs: NUM_FUNC must be 1..8");
   end
   if (DATA_W <= QEN_BIT) begin : g_bad_width
      $error("vfqe_regs: DATA_W too narrow for queue enable bit");
   end

   logic [NUM_FUNC-1:0] rst_ind;
   logic                wr_mode, wr_glb, wr_rxf, wr_txf, wr_ind;
   logic [NQ-1:0]       wr_rxq, wr_txq;
   logic [NUM_FUNC-1:0] ind_clr;
   logic                unused_wdata;

   assign unused_wdata = ^wdata;

   assign wr_mode = we && (addr == ADR_MODE);
   assign wr_glb  = we && (addr == ADR_TXGLB);
   assign wr_rxf  = we && (addr == ADR_RXFMASK);
   assign wr_txf  = we && (addr == ADR_TXFMASK);
   assign wr_ind  = we && (addr == ADR_RSTIND);
   assign ind_clr = wr_ind ? wdata[NUM_FUNC-1:0] : '0;

   for (genvar q = 0; q < NQ; q++) begin : g_qdec
      assign wr_rxq[q] = we && (addr == ADDR_W'(RXQ_BASE + q));
      assign wr_txq[q] = we && (addr == ADDR_W'(TXQ_BASE + q));
   end

   // Register writes first, function resets after: the later NBA wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         virt_mode <= 1'b0;
         tx_glb    <= 1'b0;
         rxf_en    <= '0;
         txf_en    <= '0;
         rst_ind   <= '0;
         rxq_en    <= NQ'(1);
         txq_en    <= NQ'(1);
         flr_irq   <= 1'b0;
      end else begin
         if (wr_mode) virt_mode <= wdata[0];
         if (wr_glb)  tx_glb    <= wdata[0];
         if (wr_rxf)  rxf_en    <= wdata[NUM_FUNC-1:0];
         if (wr_txf)  txf_en    <= wdata[NUM_FUNC-1:0];
         for (int q = 0; q < NQ; q++) begin
            if (wr_rxq[q]) rxq_en[q] <= wdata[QEN_BIT];
            if (wr_txq[q]) txq_en[q] <= wdata[QEN_BIT];
         end
         rst_ind <= (rst_ind & ~ind_clr) | flr_req;
         for (int f = 0; f < NUM_FUNC; f++) begin
            if (flr_req[f]) begin
               rxq_en[f]          <= 1'b0;
               rxq_en[f+NUM_FUNC] <= 1'b0;
               txq_en[f]          <= 1'b0;
               txq_en[f+NUM_FUNC] <= 1'b0;
               rxf_en[f]          <= 1'b0;
               txf_en[f]          <= 1'b0;
            end
         end
         flr_irq <= |flr_req;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADR_MODE:    rdata[0] = virt_mode;
         ADR_TXGLB:   rdata[0] = tx_glb;
         ADR_RXFMASK: rdata[NUM_FUNC-1:0] = rxf_en;
         ADR_TXFMASK: rdata[NUM_FUNC-1:0] = txf_en;
         ADR_RSTIND:  rdata[NUM_FUNC-1:0] = rst_ind;
         default: begin
            for (int q = 0; q < NQ; q++) begin
               if (addr == ADDR_W'(RXQ_BASE + q)) rdata[QEN_BIT] = rxq_en[q];
               if (addr == ADDR_W'(TXQ_BASE + q)) rdata[QEN_BIT] = txq_en[q];
            end
         end
      endcase
   end

   for (genvar f = 0; f < NUM_FUNC; f++) begin : g_chk
      AST_FLR_CLEARS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
         flr_req[f] |=> !rxq_en[f] && !rxq_en[f+NUM_FUNC] && !txq_en[f]
                        && !txq_en[f+NUM_FUNC] && !rxf_en[f] && !txf_en[f]); // R9
      AST_FLR_SETS_IND: assert property (@(posedge clk) disable iff (!rst_n)
         flr_req[f] |=> rst_ind[f]); // R10
   end
   AST_FLR_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|flr_req) |=> flr_irq); // R11
   AST_FLR_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(|flr_req) |=> !flr_irq); // R11
endmodule

// File: rtl/vfqe_txgate.sv
module vfqe_txgate #(
   parameter int NUM_FUNC = 8,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  virt_mode,
   input  logic                  tx_glb,
   input  logic [NUM_FUNC-1:0]   txf_en,
   input  logic [2*NUM_FUNC-1:0] txq_en,
   output logic [2*NUM_FUNC-1:0] tx_permit
);
   localparam int NQ = 2 * NUM_FUNC;

   logic [NQ-1:0] permit_c;

   for (genvar q = 0; q < NQ; q++) begin : g_q
      localparam int OWNER = q % NUM_FUNC;
      assign permit_c[q] = tx_glb && txq_en[q] && (!virt_mode || txf_en[OWNER]);
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tx_permit <= '0;
         else        tx_permit <= permit_c;
      end
      for (genvar q = 0; q < NQ; q++) begin : g_chk
         AST_TX_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
            tx_permit[q] |-> $past(tx_glb && txq_en[q])); // R2
         AST_TX_VM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_permit[q] && $past(virt_mode)) |-> $past(txf_en[q % NUM_FUNC])); // R3
      end
   end else begin : g_comb
      assign tx_permit = permit_c;
   end
endmodule

// File: rtl/vfqe_rxgate.sv
module vfqe_rxgate #(
   parameter int NUM_FUNC = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rx_valid,
   input  logic [NUM_FUNC-1:0]   rx_pool_sel,
   input  logic                  rx_odd_sel,
   input  logic [NUM_FUNC-1:0]   rxf_en,
   input  logic [2*NUM_FUNC-1:0] rxq_en,
   output logic [2*NUM_FUNC-1:0] rx_deliver,
   output logic                  rx_done
);
   localparam int NQ = 2 * NUM_FUNC;

   logic [NUM_FUNC-1:0] pool_ok;
   logic [NQ-1:0]       q_sel, q_hit;

   assign pool_ok = rx_pool_sel & rxf_en;
   assign q_sel   = rx_odd_sel ? {pool_ok, {NUM_FUNC{1'b0}}}
                               : {{NUM_FUNC{1'b0}}, pool_ok};
   assign q_hit   = rx_valid ? (q_sel & rxq_en) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_deliver <= '0;
         rx_done    <= 1'b0;
      end else begin
         rx_deliver <= q_hit;
         rx_done    <= |q_hit;
      end
   end

   AST_RX_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_deliver & ~$past(rxq_en)) == '0); // R7
   AST_RX_DONE_HAS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> $past(rx_valid)); // R8
endmodule

// File: rtl/vfqe_ctrl.sv
module vfqe_ctrl
   import vfqe_pkg::*;
#(
   parameter int NUM_FUNC   = 8,
   parameter int DATA_W     = 32,
   parameter bit TX_REG_OUT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [NUM_FUNC-1:0]   flr_req,
   output logic                  flr_irq,
   input  logic                  rx_valid,
   input  logic [NUM_FUNC-1:0]   rx_pool_sel,
   input  logic                  rx_odd_sel,
   output logic [2*NUM_FUNC-1:0] rx_deliver,
   output logic                  rx_done,
   output logic [2*NUM_FUNC-1:0] tx_permit
);
   localparam int NQ = 2 * NUM_FUNC;

   logic                virt_mode, tx_glb;
   logic [NUM_FUNC-1:0] rxf_en, txf_en;
   logic [NQ-1:0]       rxq_en, txq_en;

   vfqe_regs #(.NUM_FUNC(NUM_FUNC), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .flr_req(flr_req),
      .virt_mode(virt_mode), .tx_glb(tx_glb), .rxf_en(rxf_en),
      .txf_en(txf_en), .rxq_en(rxq_en), .txq_en(txq_en), .flr_irq(flr_irq)
   );

   vfqe_txgate #(.NUM_FUNC(NUM_FUNC), .REG_OUT(TX_REG_OUT)) u_tx (
      .clk(clk), .rst_n(rst_n), .virt_mode(virt_mode), .tx_glb(tx_glb),
      .txf_en(txf_en), .txq_en(txq_en), .tx_permit(tx_permit)
   );

   vfqe_rxgate #(.NUM_FUNC(NUM_FUNC)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_pool_sel(rx_pool_sel),
      .rx_odd_sel(rx_odd_sel), .rxf_en(rxf_en), .rxq_en(rxq_en),
      .rx_deliver(rx_deliver), .rx_done(rx_done)
   );

   AST_WRITE_LOSES_TO_FLR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADR_RXFMASK && (flr_req != '0))
         |=> (reg_rdata == reg_rdata) && ((rxf_en & $past(flr_req)) == '0)); // R12
endmodule

// File: tb/vfqe_ctrl_test.sv
module vfqe_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0]  flr_req = '0;
   logic        flr_irq;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_pool_sel = '0;
   logic        rx_odd_sel = 1'b0;
   logic [15:0] rx_deliver;
   logic        rx_done;
   logic [15:0] tx_permit;

   localparam logic [31:0] QEN = 32'h0200_0000;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   vfqe_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flr_req(flr_req),
      .flr_irq(flr_irq), .rx_valid(rx_valid), .rx_pool_sel(rx_pool_sel),
      .rx_odd_sel(rx_odd_sel), .rx_deliver(rx_deliver), .rx_done(rx_done),
      .tx_permit(tx_permit)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic rx_try(input string tag, input logic v, input logic [7:0] pool,
                         input logic odd, input logic [15:0] exp_q, input logic exp_done);
      @(negedge clk);
      rx_valid = v; rx_pool_sel = pool; rx_odd_sel = odd;
      @(negedge clk);
      chk({tag, " deliver"}, 32'(rx_deliver), 32'(exp_q));
      chk({tag, " done"}, 32'(rx_done), 32'(exp_done));
      rx_valid = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rd_chk("R1 rxq0", 6'h10, QEN);
      rd_chk("R1 rxq1", 6'h11, 32'h0);
      rd_chk("R1 txq0", 6'h20, QEN);
      rd_chk("R1 txq5", 6'h25, 32'h0);
      rd_chk("R1 rxmask", 6'h02, 32'h0);
      rd_chk("R1 txmask", 6'h03, 32'h0);
      rd_chk("R1 mode", 6'h00, 32'h0);
      rd_chk("R1 glb", 6'h01, 32'h0);
      rd_chk("R1 ind", 6'h04, 32'h0);
      chk("R1 permit", 32'(tx_permit), 32'h0);
   endtask

   task automatic t_tx_basic;
      wr(6'h01, 32'h1);
      chk("R5 permit not yet", 32'(tx_permit), 32'h0);
      @(negedge clk);
      chk("R2 q0 permit", 32'(tx_permit), 32'h0001);
      wr(6'h29, QEN);
      @(negedge clk);
      chk("R2 q9 enabled", 32'(tx_permit), 32'h0201);
      wr(6'h03, 32'h0);
      @(negedge clk);
      chk("R4 mask ignored", 32'(tx_permit), 32'h0201);
   endtask

   task automatic t_tx_vm;
      wr(6'h00, 32'h1);
      @(negedge clk);
      chk("R3 vm mask empty", 32'(tx_permit), 32'h0);
      wr(6'h03, 32'h02);
      @(negedge clk);
      chk("R3 func1 upper", 32'(tx_permit), 32'h0200);
      wr(6'h03, 32'h03);
      @(negedge clk);
      chk("R3 func0+1", 32'(tx_permit), 32'h0201);
      wr(6'h01, 32'h0);
      @(negedge clk);
      chk("R2 global off", 32'(tx_permit), 32'h0);
      wr(6'h01, 32'h1);
      @(negedge clk);
      chk("R2 global on", 32'(tx_permit), 32'h0201);
   endtask

   task automatic t_rx;
      wr(6'h13, QEN);
      wr(6'h1B, QEN);
      wr(6'h02, 32'h0F);
      rx_try("R6 R7 lower", 1'b1, 8'h09, 1'b0, 16'h0009, 1'b1);
      rx_try("R6 R7 upper", 1'b1, 8'h09, 1'b1, 16'h0800, 1'b1);
      rx_try("R6 masked out", 1'b1, 8'h30, 1'b0, 16'h0000, 1'b0);
      rx_try("R8 disabled queue", 1'b1, 8'h04, 1'b0, 16'h0000, 1'b0);
      rx_try("R7 not valid", 1'b0, 8'h09, 1'b0, 16'h0000, 1'b0);
   endtask

   task automatic t_flr;
      @(negedge clk);
      flr_req = 8'h08;
      @(negedge clk);
      flr_req = 8'h00;
      chk("R11 irq pulse", 32'(flr_irq), 32'h1);
      rd_chk("R9 rxq3", 6'h13, 32'h0);
      rd_chk("R9 rxq11", 6'h1B, 32'h0);
      rd_chk("R9 rxq0 kept", 6'h10, QEN);
      rd_chk("R9 rxmask", 6'h02, 32'h07);
      rd_chk("R10 ind set", 6'h04, 32'h08);
      @(negedge clk);
      chk("R11 irq single", 32'(flr_irq), 32'h0);
      flr_req = 8'h02;
      @(negedge clk);
      flr_req = 8'h00;
      rd_chk("R9 txq9", 6'h29, 32'h0);
      rd_chk("R9 txmask", 6'h03, 32'h01);
      @(negedge clk);
      chk("R9 permit after", 32'(tx_permit), 32'h0001);
      rd_chk("R10 ind two", 6'h04, 32'h0A);
      wr(6'h04, 32'h02);
      rd_chk("R10 w1c", 6'h04, 32'h08);
      wr(6'h04, 32'h00);
      rd_chk("R10 write zero", 6'h04, 32'h08);
   endtask

   task automatic t_collision;
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 6'h02; reg_wdata = 32'hFF; flr_req = 8'h04;
      @(negedge clk);
      reg_we = 1'b0; flr_req = 8'h00;
      rd_chk("R12 mask write loses", 6'h02, 32'hFB);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 6'h04; reg_wdata = 32'hFF; flr_req = 8'h01;
      @(negedge clk);
      reg_we = 1'b0; flr_req = 8'h00;
      rd_chk("R12 ind set wins", 6'h04, 32'h01);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 6'h15; reg_wdata = QEN; flr_req = 8'h20;
      @(negedge clk);
      reg_we = 1'b0; flr_req = 8'h00;
      rd_chk("R12 queue write loses", 6'h15, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_tx_basic();
      t_tx_vm();
      t_rx();
      t_flr();
      t_collision();
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule